// File: doc/BRIEF.md
# Full-Duplex Serial Transceiver with Oversampled Receive

The block is a full-duplex asynchronous serial port. The transmit side takes a word from a parallel valid/ready handshake into a one-deep holding register, then shifts it out on `txd` as a frame: a low start bit, the data bits least-significant first, an optional ninth bit, and a high stop bit. The receive side watches `rxd` and runs sixteen ticks per bit. It decides every bit by a two-of-three vote over ticks 8, 9 and 10. The finished word goes into one receive register, together with its noise, framing and overrun flags.

Both bit clocks come from one shared prescaler. The prescaler divides the system clock by 2·PR, where PR is picked from {1, 3, 4, 13}. Two separate power-of-two dividers follow it, one for transmit and one for receive, so the two directions may run at different rates.

The transmit machine has four states:
- `TX_IDLE`: waits until the holding register is full and a transmit tick arrives, then moves to `TX_START`.
- `TX_START`: after 16 ticks, moves to `TX_DATA`.
- `TX_DATA`: after the last data bit, moves to `TX_STOP`.
- `TX_STOP`: after 16 ticks, moves to `TX_START` if another word is waiting, and to `TX_IDLE` if not.

The receive machine has four states:
- `RX_IDLE`: moves to `RX_START` when it sees a low line on a receive tick.
- `RX_START`: returns to `RX_IDLE` if the vote over the start bit is high. If the vote is low, it moves to `RX_DATA`.
- `RX_DATA`: after the last data bit, moves to `RX_STOP`.
- `RX_STOP`: delivers the word and returns to `RX_IDLE`.

Top module: `uart_core`

## Requirements
- R1: After reset, `txd` is 1, `tx_ready` is 1, `tx_done` is 1, and `rx_valid`, `err_noise`, `err_frame`, `err_overrun` and `irq` are all 0.
- R2: One transmit bit lasts 16·2·PR·2^`tx_exp` clock cycles, where `pr_sel` 0,1,2,3 selects PR = 1,3,4,13. The receive bit uses `rx_exp` in the same formula.
- R3: A transmitted frame is a 0 start bit, then `tx_data[0]` first through bit 7, then `tx_data[8]` only when `nine`=1, then a 1 stop bit.
- R4: `tx_ready` is 0 while the holding register is full and the shifter is busy. A word may be written in the same cycle that the held word moves to the shifter. Words written this way leave back to back, with start edges exactly one frame length apart.
- R5: `tx_done` is 1 only when the shifter is idle and the holding register is empty. While `tx_done` is 1, `txd` is 1.
- R6: Each received bit is the majority of the line samples at oversample ticks 8, 9 and 10 of 16. If one sample disagrees, the word is still correct and `err_noise` is set with it.
- R7: If the voted stop bit is 0, `err_frame` is set and the word is still delivered.
- R8: If a frame completes while `rx_valid` is 1 and `rx_ack` is 0, `err_overrun` is set, `rx_data` keeps the old word, and the new word is dropped.
- R9: A low pulse on `rxd` that has ended before the start-bit sample ticks does not produce a word.
- R10: `rx_ack` clears `rx_valid`, `err_noise`, `err_frame` and `err_overrun` in the next cycle.
- R11: `irq` equals `rx_valid` OR `err_overrun`.
- R12: With `nine`=1 the ninth received bit appears in `rx_data[8]`. With `nine`=0, `rx_data[8]` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pr_sel | input | 2 | Shared prescale select (PR = 1,3,4,13) |
| tx_exp | input | 3 | Transmit divider exponent n (divide by 2^n) |
| rx_exp | input | 3 | Receive divider exponent n (divide by 2^n) |
| nine | input | 1 | 1 selects a ninth data bit in both directions |
| tx_data | input | 9 | Word to transmit |
| tx_valid | input | 1 | `tx_data` is offered |
| tx_ready | output | 1 | Holding register can take a word this cycle |
| tx_done | output | 1 | Transmitter idle with nothing held |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| rx_data | output | 9 | Last received word |
| rx_valid | output | 1 | Receive register holds an unread word |
| rx_ack | input | 1 | Consumes the received word and clears its flags |
| err_noise | output | 1 | Sample disagreement within the held frame |
| err_frame | output | 1 | Held frame had a low stop bit |
| err_overrun | output | 1 | A frame was dropped because the register was full |
| irq | output | 1 | Receive interrupt request |

## Verification
The hazardous coincidence is on the transmit side. At the stop-bit tick, the holding register drains into the shifter, and in that same cycle a new word from the handshake must be written into it. The bench keeps `tx_valid` high across a burst of words, so every later write lands exactly on a hand-off cycle. A scoreboard then decodes `txd`. It checks that no word is lost or repeated, and that consecutive start edges are exactly one frame length apart.

// File: rtl/uart_pkg.sv
package uart_pkg;

    typedef enum logic [1:0] {TX_IDLE, TX_START, TX_DATA, TX_STOP} tx_state_e;
    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;

    // Shared prescale factor selected by two bits
    function automatic logic [4:0] prescale_factor(input logic [1:0] sel);
        logic [4:0] f;
        case (sel)
            2'd0:    f = 5'd1;
            2'd1:    f = 5'd3;
            2'd2:    f = 5'd4;
            default: f = 5'd13;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/uart_baud_gen.sv
module uart_baud_gen
    import uart_pkg::*;
#(
    parameter int EXP_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       pr_sel,
    input  logic [EXP_W-1:0] tx_exp,
    input  logic [EXP_W-1:0] rx_exp,
    output logic             tx_tick,
    output logic             rx_tick
);
    localparam int DIV_W = 1 << EXP_W;
    localparam int PRE_W = 6;

    logic [PRE_W-1:0] pre_cnt;
    logic [PRE_W-1:0] pre_lim;
    logic             pre_tick;
    logic [EXP_W-1:0] exp_sel [2];
    logic [1:0]       ticks;

    // Prescaler period is 2*PR cycles
    assign pre_lim  = {prescale_factor(pr_sel), 1'b0} - PRE_W'(1);
    assign pre_tick = (pre_cnt >= pre_lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_cnt <= '0;
        else        pre_cnt <= pre_tick ? '0 : pre_cnt + PRE_W'(1);
    end

    assign exp_sel[0] = tx_exp;
    assign exp_sel[1] = rx_exp;

    for (genvar ch = 0; ch < 2; ch++) begin : g_div
        logic [DIV_W-1:0] cnt;
        logic [DIV_W-1:0] lim;
        assign lim       = (DIV_W'(1) << exp_sel[ch]) - DIV_W'(1);
        assign ticks[ch] = pre_tick && (cnt >= lim);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        cnt <= '0;
            else if (pre_tick) cnt <= (cnt >= lim) ? '0 : cnt + DIV_W'(1);
        end
    end

    assign tx_tick = ticks[0];
    assign rx_tick = ticks[1];

    // R2: ticks are never closer than two cycles
    assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_tick |=> !tx_tick);
    assert_rx_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_tick |=> !rx_tick);

endmodule

// File: rtl/uart_tx.sv
module uart_tx
    import uart_pkg::*;
#(
    parameter int WORD_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              nine,
    input  logic [WORD_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              tx_done,
    output logic              txd
);
    localparam int BIT_W = $clog2(WORD_W + 1);

    tx_state_e         state;
    logic [WORD_W-1:0] hold_q;
    logic [WORD_W-1:0] shf;
    logic              hold_full;
    logic [3:0]        sub;
    logic [BIT_W-1:0]  bitn;
    logic [BIT_W-1:0]  last_bit;
    logic              load;

    assign last_bit = nine ? BIT_W'(WORD_W - 1) : BIT_W'(WORD_W - 2);
    assign load     = tick && hold_full &&
                      (state == TX_IDLE || (state == TX_STOP && sub == 4'hF));
    assign tx_ready = !hold_full || load;

    // State register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= TX_IDLE;
            hold_q    <= '0;
            hold_full <= 1'b0;
            shf       <= '0;
            sub       <= '0;
            bitn      <= '0;
        end else begin
            if (tx_valid && tx_ready) begin
                hold_q    <= tx_data;
                hold_full <= 1'b1;
            end else if (load) begin
                hold_full <= 1'b0;
            end
            if (load) begin
                state <= TX_START;
                shf   <= hold_q;
                sub   <= '0;
            end else if (tick) begin
                unique case (state)
                    TX_IDLE:  sub <= '0;
                    TX_START: begin
                        sub <= sub + 4'd1;
                        if (sub == 4'hF) begin
                            state <= TX_DATA;
                            bitn  <= '0;
                        end
                    end
                    TX_DATA: begin
                        sub <= sub + 4'd1;
                        if (sub == 4'hF) begin
                            shf  <= shf >> 1;
                            bitn <= bitn + BIT_W'(1);
                            if (bitn == last_bit) state <= TX_STOP;
                        end
                    end
                    TX_STOP: begin
                        sub <= sub + 4'd1;
                        if (sub == 4'hF) state <= TX_IDLE;
                    end
                endcase
            end
        end
    end

    // Outputs
    always_comb begin
        unique case (state)
            TX_IDLE:  txd = 1'b1;
            TX_START: txd = 1'b0;
            TX_DATA:  txd = shf[0];
            TX_STOP:  txd = 1'b1;
        endcase
        tx_done = (state == TX_IDLE) && !hold_full;
    end

    assert_accept_fills_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> hold_full);
    assert_done_line_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> txd);

endmodule

// File: rtl/uart_rx.sv
module uart_rx
    import uart_pkg::*;
#(
    parameter int WORD_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              nine,
    input  logic              rxd,
    input  logic              rx_ack,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              err_noise,
    output logic              err_frame,
    output logic              err_overrun
);
    localparam int BIT_W = $clog2(WORD_W + 1);

    rx_state_e         state;
    logic              sync1, sync2;
    logic [2:0]        samp;
    logic [3:0]        sub;
    logic [BIT_W-1:0]  bitn;
    logic [BIT_W-1:0]  last_bit;
    logic [WORD_W-1:0] shf;
    logic              noise_acc;
    logic              vote, disagree, bit_end, frame_done;
    logic [WORD_W-1:0] word;

    assign last_bit   = nine ? BIT_W'(WORD_W - 1) : BIT_W'(WORD_W - 2);
    assign vote       = (samp[0] & samp[1]) | (samp[0] & samp[2]) | (samp[1] & samp[2]);
    assign disagree   = (samp != 3'b000) && (samp != 3'b111);
    assign bit_end    = tick && (sub == 4'hF);
    assign frame_done = bit_end && (state == RX_STOP);
    assign word       = nine ? shf : {1'b0, shf[WORD_W-1:1]};

    // State register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1     <= 1'b1;
            sync2     <= 1'b1;
            state     <= RX_IDLE;
            samp      <= 3'b111;
            sub       <= '0;
            bitn      <= '0;
            shf       <= '0;
            noise_acc <= 1'b0;
        end else begin
            sync1 <= rxd;
            sync2 <= sync1;
            if (tick) begin
                if (state != RX_IDLE) begin
                    sub <= sub + 4'd1;
                    if (sub >= 4'd7 && sub <= 4'd9) samp <= {samp[1:0], sync2};
                end
                unique case (state)
                    RX_IDLE: begin
                        sub <= '0;
                        if (!sync2) state <= RX_START;
                    end
                    RX_START: if (sub == 4'hF) begin
                        if (!vote) begin
                            state     <= RX_DATA;
                            bitn      <= '0;
                            noise_acc <= disagree;
                        end else begin
                            state <= RX_IDLE;
                        end
                    end
                    RX_DATA: if (sub == 4'hF) begin
                        shf       <= {vote, shf[WORD_W-1:1]};
                        noise_acc <= noise_acc | disagree;
                        bitn      <= bitn + BIT_W'(1);
                        if (bitn == last_bit) state <= RX_STOP;
                    end
                    RX_STOP: if (sub == 4'hF) state <= RX_IDLE;
                endcase
            end
        end
    end

    // Output registers and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data     <= '0;
            rx_valid    <= 1'b0;
            err_noise   <= 1'b0;
            err_frame   <= 1'b0;
            err_overrun <= 1'b0;
        end else if (frame_done) begin
            if (rx_valid && !rx_ack) begin
                err_overrun <= 1'b1;
            end else begin
                rx_data     <= word;
                rx_valid    <= 1'b1;
                err_noise   <= noise_acc | disagree;
                err_frame   <= !vote;
                err_overrun <= 1'b0;
            end
        end else if (rx_ack) begin
            rx_valid    <= 1'b0;
            err_noise   <= 1'b0;
            err_frame   <= 1'b0;
            err_overrun <= 1'b0;
        end
    end

    assert_overrun_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && rx_valid && !rx_ack) |=> (err_overrun && $stable(rx_data)));
    assert_ack_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ack && !frame_done) |=> (!rx_valid && !err_overrun && !err_noise));
    assert_frame_flag_with_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_frame |-> rx_valid);

endmodule

// File: rtl/uart_core.sv
module uart_core
    import uart_pkg::*;
#(
    parameter int WORD_W = 9,
    parameter int EXP_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        pr_sel,
    input  logic [EXP_W-1:0]  tx_exp,
    input  logic [EXP_W-1:0]  rx_exp,
    input  logic              nine,
    input  logic [WORD_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              tx_done,
    output logic              txd,
    input  logic              rxd,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic              rx_ack,
    output logic              err_noise,
    output logic              err_frame,
    output logic              err_overrun,
    output logic              irq
);
    logic tx_tick, rx_tick;

    uart_baud_gen #(.EXP_W(EXP_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .pr_sel(pr_sel), .tx_exp(tx_exp),
        .rx_exp(rx_exp), .tx_tick(tx_tick), .rx_tick(rx_tick)
    );

    uart_tx #(.WORD_W(WORD_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tx_tick), .nine(nine),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_done(tx_done), .txd(txd)
    );

    uart_rx #(.WORD_W(WORD_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(rx_tick), .nine(nine), .rxd(rxd),
        .rx_ack(rx_ack), .rx_data(rx_data), .rx_valid(rx_valid),
        .err_noise(err_noise), .err_frame(err_frame), .err_overrun(err_overrun)
    );

    assign irq = rx_valid | err_overrun;

endmodule

// File: tb/tb_uart_core.sv
module tb_uart_core;
    localparam int CLK_P  = 10;
    localparam int TX_BIT = 32;   // PR=1, tx_exp=0
    localparam int RX_BIT = 128;  // PR=1, rx_exp=2

    logic       clk = 0, rst_n = 0;
    logic [1:0] pr_sel = 0;
    logic [2:0] tx_exp = 0, rx_exp = 3'd2;
    logic       nine = 0;
    logic [8:0] tx_data = 0;
    logic       tx_valid = 0, rx_ack = 0, rxd = 1;
    logic       tx_ready, tx_done, txd, rx_valid, err_noise, err_frame, err_overrun, irq;
    logic [8:0] rx_data;

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit mon_en = 0;
    logic [8:0] txq[$];
    int st[$];

    always #(CLK_P/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    uart_core dut (
        .clk(clk), .rst_n(rst_n), .pr_sel(pr_sel), .tx_exp(tx_exp), .rx_exp(rx_exp),
        .nine(nine), .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_done(tx_done), .txd(txd), .rxd(rxd), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_ack(rx_ack), .err_noise(err_noise), .err_frame(err_frame),
        .err_overrun(err_overrun), .irq(irq)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_all();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    // Driver: leaves tx_valid high so a following put lands on the hand-off
    task automatic put(input logic [8:0] w);
        tx_data  = w;
        tx_valid = 1;
        if (mon_en) txq.push_back(w);
        while (!tx_ready) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic ack();
        rx_ack = 1;
        @(negedge clk);
        rx_ack = 0;
    endtask

    task automatic rx_frame(input logic [8:0] w, input bit stop_v, input int gbit);
        int nb;
        logic v;
        nb = nine ? 9 : 8;
        for (int c = 0; c < nb + 2; c++) begin
            if (c == 0)       v = 1'b0;
            else if (c <= nb) v = w[c-1];
            else              v = stop_v;
            for (int k = 0; k < RX_BIT; k++) begin
                rxd = (c == gbit && k >= 60 && k < 68) ? ~v : v;
                @(negedge clk);
            end
        end
        rxd = 1;
        repeat (2 * RX_BIT) @(negedge clk);
    endtask

    // Monitor: decodes txd and compares with the scoreboard queue (R3)
    initial begin
        logic [8:0] w, e;
        int nb;
        forever begin
            @(negedge clk);
            if (mon_en && txd == 0) begin
                st.push_back(cyc);
                repeat (TX_BIT/2 - 1) @(negedge clk);
                chk(txd == 0, "R3 start bit", txd, 0);
                nb = nine ? 9 : 8;
                w = 0;
                for (int i = 0; i < nb; i++) begin
                    repeat (TX_BIT) @(negedge clk);
                    w[i] = txd;
                end
                repeat (TX_BIT) @(negedge clk);
                chk(txd == 1, "R3 stop bit", txd, 1);
                if (txq.size() > 0) begin
                    e = txq.pop_front();
                    chk(w == e, "R3 tx word", w, e);
                end else begin
                    chk(0, "R3 unexpected frame", w, 0);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        finish_all();
    end

    initial begin
        int cnt;
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1
        chk(txd == 1 && tx_ready == 1 && tx_done == 1, "R1 tx reset", {txd, tx_ready, tx_done}, 3'b111);
        chk({rx_valid, err_noise, err_frame, err_overrun, irq} == 0, "R1 rx reset",
            {rx_valid, err_noise, err_frame, err_overrun, irq}, 0);

        // Burst with tx_valid held: R3, R4, R5
        mon_en = 1;
        st.delete();
        put(9'h0A5);
        put(9'h03C);
        chk(tx_ready == 0, "R4 ready low when hold full", tx_ready, 0);
        chk(tx_done == 0, "R5 done low while busy", tx_done, 0);
        put(9'h0FF);
        put(9'h000);
        tx_valid = 0;
        repeat (3 * 10 * TX_BIT) @(negedge clk);
        chk(st.size() == 4, "R4 frame count", st.size(), 4);
        if (st.size() == 4)
            for (int i = 1; i < 4; i++)
                chk(st[i] - st[i-1] == 10 * TX_BIT, "R4 back-to-back spacing", st[i] - st[i-1], 10 * TX_BIT);
        chk(tx_done == 1 && txd == 1, "R5 done when drained", tx_done, 1);
        chk(txq.size() == 0, "R3 all words sent", txq.size(), 0);

        // Nine-bit transmit (R3)
        nine = 1;
        put(9'h1A5);
        put(9'h055);
        tx_valid = 0;
        repeat (3 * 11 * TX_BIT) @(negedge clk);
        chk(txq.size() == 0, "R3 nine-bit words sent", txq.size(), 0);
        nine = 0;
        mon_en = 0;

        // Baud rate (R2): PR=3, n=1 -> 192 cycles; PR=13, n=0 -> 416
        pr_sel = 2'd1; tx_exp = 3'd1;
        put(9'h001); tx_valid = 0;
        while (txd) @(negedge clk);
        cnt = 0;
        while (!txd) begin cnt++; @(negedge clk); end
        chk(cnt == 192, "R2 bit time PR=3 n=1", cnt, 192);
        while (!tx_done) @(negedge clk);
        pr_sel = 2'd3; tx_exp = 3'd0;
        put(9'h001); tx_valid = 0;
        while (txd) @(negedge clk);
        cnt = 0;
        while (!txd) begin cnt++; @(negedge clk); end
        chk(cnt == 416, "R2 bit time PR=13 n=0", cnt, 416);
        while (!tx_done) @(negedge clk);
        pr_sel = 2'd0;

        // Clean receive, R11, R12 (8-bit), R10
        rx_frame(9'h05A, 1, -1);
        chk(rx_valid && rx_data == 9'h05A, "R6 clean word", rx_data, 9'h05A);
        chk(err_noise == 0 && err_frame == 0, "R6 no flags", {err_noise, err_frame}, 0);
        chk(irq == 1, "R11 irq on data", irq, 1);
        chk(rx_data[8] == 0, "R12 bit8 zero in 8-bit mode", rx_data[8], 0);
        ack();
        chk(rx_valid == 0 && irq == 0, "R10 ack clears", {rx_valid, irq}, 0);

        // Noise: one sample flipped in data bit index 3 (cell 4)
        rx_frame(9'h0C3, 1, 4);
        chk(rx_data == 9'h0C3, "R6 majority word", rx_data, 9'h0C3);
        chk(err_noise == 1, "R6 noise flag", err_noise, 1);
        ack();
        chk(err_noise == 0, "R10 noise cleared", err_noise, 0);

        // Framing error
        rx_frame(9'h081, 0, -1);
        chk(rx_valid && rx_data == 9'h081, "R7 word kept", rx_data, 9'h081);
        chk(err_frame == 1, "R7 frame flag", err_frame, 1);
        ack();
        chk(err_frame == 0 && rx_valid == 0, "R10 frame cleared", err_frame, 0);

        // Overrun
        rx_frame(9'h011, 1, -1);
        rx_frame(9'h022, 1, -1);
        chk(err_overrun == 1, "R8 overrun flag", err_overrun, 1);
        chk(rx_data == 9'h011, "R8 old word kept", rx_data, 9'h011);
        chk(irq == 1, "R11 irq on overrun", irq, 1);
        ack();
        chk(err_overrun == 0 && rx_valid == 0, "R10 overrun cleared", err_overrun, 0);

        // False start
        rxd = 0;
        repeat (24) @(negedge clk);
        rxd = 1;
        repeat (3 * RX_BIT) @(negedge clk);
        chk(rx_valid == 0, "R9 short pulse ignored", rx_valid, 0);

        // Nine-bit receive
        nine = 1;
        rx_frame(9'h1B4, 1, -1);
        chk(rx_valid && rx_data == 9'h1B4, "R12 nine-bit word", rx_data, 9'h1B4);
        ack();
        nine = 0;

        finish_all();
    end
endmodule